// File: doc/BRIEF.md
# Staleness-Checked Private Cache Controller

This controller sits in front of a small direct-mapped private data cache. Each line keeps a valid bit, a tag, a mode bit and a version number. The mode bit is 0 for Normal and 1 for bounded-stale. It is set when the line is filled, from a table of four address ranges. A line is bounded-stale when its address falls inside any enabled range. An address that matches no enabled range is Normal.

A read to a present Normal line always hits. A read to a present bounded-stale line takes its age into account. The age is the core's current iteration minus the line's version, taken modulo 2^VW. If the age is at most the staleness limit, the read is served at once. Otherwise the line is invalidated and refetched.

On every miss the controller issues a single refill toward the next memory level. It stamps the refilled line with the iteration value seen when the request was accepted. Lines are never written by the core, so an eviction is a silent drop.

Top module: `stale_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `rd_ready` is 1 and `fill_req` is 0. The first read to any index is therefore a miss.
- R2: A line takes mode 1 (bounded-stale) when its fill address lies within [base, limit] of an enabled region entry, inclusive at both ends. Otherwise it takes mode 0 (Normal). A disabled entry never matches.
- R3: An accepted read to a present bounded-stale line whose age is at most `stale_limit` reports `rd_class` = 1 (hit). In that same cycle it raises `rd_done` with the stored data, and no refill follows.
- R4: An accepted read to a present bounded-stale line whose age exceeds `stale_limit` reports `rd_class` = 2 (stale-miss). On the next cycle `fill_req` is 1 and `fill_addr` equals the read address.
- R5: An accepted read whose index holds an invalid line, or a line with a different tag, reports `rd_class` = 3 (miss) and starts a refill the same way.
- R6: While a refill is pending, a cycle with `fill_valid` raises `rd_done` with `rd_data` = `fill_data`. The line is then stored with the new tag, its mode, that data, and the iteration value captured when the request was accepted.
- R7: A present Normal line hits (`rd_class` = 1) whatever its age.
- R8: Only one refill is outstanding. From the cycle after a missing read until `fill_valid`, `rd_ready` is 0, `fill_req` stays 1 with a stable `fill_addr`, and any `rd_req` is ignored (`rd_class` = 0, no `rd_done`).
- R9: Age is computed modulo 2^VW. With VW = 4, version 14 and iteration 1 give an age of 3.
- R10: The cache is direct-mapped on index = `rd_addr[3:0]` and tag = `rd_addr[15:4]`. A fill to an index replaces whatever line was there, and the replacement sends no traffic other than the single refill request.
- R11: `rd_class` is 0 whenever `rd_req` is 0 or `rd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, accepted when `rd_ready` is 1 |
| rd_addr | input | AW | Word address of the read |
| rd_ready | output | 1 | Controller can accept a read |
| rd_class | output | 2 | Lookup result: 0 none, 1 hit, 2 stale-miss, 3 miss |
| rd_done | output | 1 | Read data valid this cycle |
| rd_data | output | DW | Read data |
| iter_now | input | VW | Core's current iteration, modulo 2^VW |
| stale_limit | input | VW | Largest age that still hits |
| rgn_en | input | RN | Enable bit per region entry |
| rgn_base | input | RN*AW | Lower bound per entry, entry g at bits [g*AW +: AW] |
| rgn_limit | input | RN*AW | Upper bound per entry, same packing |
| fill_req | output | 1 | Refill request pending |
| fill_addr | output | AW | Address being refilled |
| fill_valid | input | 1 | Refill data present this cycle |
| fill_data | input | DW | Refill data |

## Verification
The assertions check the refill handshake on every cycle:
- a stale-miss or miss is followed by a request for exactly that address;
- the request holds steady until data returns;
- nothing completes or classifies while the refill waits;
- returning data completes the read.

Only the bench's scenarios can show the rest, because those outcomes depend on history. This covers the classification itself: the age comparison across the modulo wrap, Normal lines ignoring age, region matching on range boundaries and disabled entries, replacement on a tag conflict, and the version stamp given to a refilled line.

// File: rtl/stale_cache_ctrl.sv
module stale_cache_ctrl #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int VW    = 4,
  parameter int LINES = 16,
  parameter int RN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_ready,
  output logic [1:0]       rd_class,
  output logic             rd_done,
  output logic [DW-1:0]    rd_data,
  input  logic [VW-1:0]    iter_now,
  input  logic [VW-1:0]    stale_limit,
  input  logic [RN-1:0]    rgn_en,
  input  logic [RN*AW-1:0] rgn_base,
  input  logic [RN*AW-1:0] rgn_limit,
  output logic             fill_req,
  output logic [AW-1:0]    fill_addr,
  input  logic             fill_valid,
  input  logic [DW-1:0]    fill_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  logic [LINES-1:0] v_q, m_q;
  logic [TW-1:0]    tag_q  [LINES];
  logic [VW-1:0]    ver_q  [LINES];
  logic [DW-1:0]    data_q [LINES];

  logic          busy_q, pend_mode_q;
  logic [AW-1:0] pend_addr_q;
  logic [VW-1:0] pend_ver_q;

  logic [RN-1:0] rgn_hit;
  genvar g;
  generate
    for (g = 0; g < RN; g++) begin : g_rgn
      assign rgn_hit[g] = rgn_en[g] && (rd_addr >= rgn_base[g*AW +: AW])
                                    && (rd_addr <= rgn_limit[g*AW +: AW]);
    end
  endgenerate

  wire [IW-1:0] idx     = rd_addr[IW-1:0];
  wire [TW-1:0] tg      = rd_addr[AW-1:IW];
  wire [IW-1:0] pidx    = pend_addr_q[IW-1:0];
  wire          present = v_q[idx] && (tag_q[idx] == tg);
  wire [VW-1:0] age     = iter_now - ver_q[idx];
  wire          too_old = m_q[idx] && (age > stale_limit);
  wire          take    = rd_req && !busy_q;
  wire          hit     = present && !too_old;
  wire          landing = busy_q && fill_valid;

  assign rd_ready  = !busy_q;
  assign rd_class  = !take ? 2'd0 : !present ? 2'd3 : too_old ? 2'd2 : 2'd1;
  assign rd_done   = (take && hit) || landing;
  assign rd_data   = busy_q ? fill_data : data_q[idx];
  assign fill_req  = busy_q;
  assign fill_addr = pend_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      v_q    <= '0;
    end else if (landing) begin
      busy_q    <= 1'b0;
      v_q[pidx] <= 1'b1;
    end else if (take && !hit) begin
      busy_q   <= 1'b1;
      v_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !hit) begin
      pend_addr_q <= rd_addr;
      pend_mode_q <= |rgn_hit;
      pend_ver_q  <= iter_now;
    end
    if (landing) begin
      m_q[pidx]    <= pend_mode_q;
      tag_q[pidx]  <= pend_addr_q[AW-1:IW];
      ver_q[pidx]  <= pend_ver_q;
      data_q[pidx] <= fill_data;
    end
  end

  p_stale_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_class == 2'd2 |=> fill_req && fill_addr == $past(rd_addr));
  p_cold_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_class == 2'd3 |=> fill_req && fill_addr == $past(rd_addr));
  p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_class == 2'd1 |=> !fill_req);
  p_fill_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr));
  p_quiet_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && !fill_valid |-> !rd_done && rd_class == 2'd0);
  p_fill_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_valid |-> rd_done && rd_data == fill_data && rd_class == 2'd0);
  p_idle_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> rd_class == 2'd0);
endmodule

// File: tb/tb_stale_cache_ctrl.sv
`timescale 1ns/1ps
module tb_stale_cache_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_ready, rd_done, fill_req;
  logic [1:0]  rd_class;
  logic [31:0] rd_data, fill_data = '0;
  logic [3:0]  iter_now = '0, stale_limit = '0;
  logic [3:0]  rgn_en = 4'b0111;
  logic [63:0] rgn_base  = {16'h3000, 16'h2030, 16'h2000, 16'h1000};
  logic [63:0] rgn_limit = {16'h30FF, 16'h2100, 16'h203F, 16'h10FF};
  logic [15:0] fill_addr;
  logic        fill_valid = 1'b0;

  int n_chk = 0, n_bad = 0, n_fill = 0;
  bit mv[16]; bit mm[16];
  logic [11:0] mt[16]; logic [3:0] mver[16]; logic [31:0] md[16];

  always #10 clk = ~clk;

  stale_cache_ctrl dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit bounded(input logic [15:0] a);
    return (a >= 16'h1000 && a <= 16'h10FF) || (a >= 16'h2000 && a <= 16'h2100);
  endfunction

  task automatic do_read(input logic [15:0] a);
    logic [3:0] ix = a[3:0];
    logic [3:0] ag;
    logic [1:0] ec;
    logic [31:0] val;
    string rq;
    ag = iter_now - mver[ix];
    if (!mv[ix] || mt[ix] != a[15:4]) begin ec = 2'd3; rq = "R5/R10"; end
    else if (mm[ix] && ag > stale_limit) begin ec = 2'd2; rq = (iter_now < mver[ix]) ? "R9" : "R4"; end
    else begin ec = 2'd1; rq = !mm[ix] ? "R7" : (iter_now < mver[ix]) ? "R9" : "R3"; end
    @(negedge clk); rd_req = 1'b1; rd_addr = a; #1;
    check(rd_class == ec, rq, rd_class, ec);
    if (ec == 2'd1) check(rd_done && rd_data == md[ix], "R3", rd_data, md[ix]);
    else check(!rd_done, rq, rd_done, 0);
    @(posedge clk); #1;
    if (ec == 2'd1) begin
      check(!fill_req, "R3", fill_req, 0);
      @(negedge clk); rd_req = 1'b0;
    end else begin
      check(fill_req && fill_addr == a, rq, fill_addr, a);
      check(!rd_ready && rd_class == 2'd0 && !rd_done, "R8", {rd_ready, rd_class, rd_done}, 0);
      @(posedge clk); #1;
      check(fill_req && fill_addr == a, "R8", fill_addr, a);
      @(negedge clk);
      n_fill++;
      val = {a, n_fill[7:0], 8'h5A};
      rd_req = 1'b0; fill_valid = 1'b1; fill_data = val; #1;
      check(rd_done && rd_data == val, "R6", rd_data, val);
      @(negedge clk); fill_valid = 1'b0; #1;
      check(rd_ready && !fill_req, "R8", {rd_ready, fill_req}, 2'b10);
      mv[ix] = 1'b1; mt[ix] = a[15:4]; mm[ix] = bounded(a); mver[ix] = iter_now; md[ix] = val;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] alist[8];
    alist = '{16'h1004, 16'h2034, 16'h3007, 16'h0007, 16'h20F9, 16'h10FF, 16'h2100, 16'h4004};
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mm[i] = 0; mt[i] = '0; mver[i] = '0; md[i] = '0; end
    repeat (3) @(posedge clk);
    #1 check(rd_ready && !fill_req, "R1", {rd_ready, fill_req}, 2'b10);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1 check(rd_class == 2'd0 && !rd_done, "R11", rd_class, 0);

    // R1: every index misses first; R2: boundaries and disabled entry via mode effects
    for (int i = 0; i < 16; i++) do_read({12'h100, i[3:0]});

    // R9: wrap of age, version 14 then iteration 1
    iter_now = 4'd14; stale_limit = 4'd0; do_read(16'h1009);
    iter_now = 4'd1;  stale_limit = 4'd3; do_read(16'h1009);
    stale_limit = 4'd2; do_read(16'h1009);

    // R7: Normal line in disabled region ignores age
    iter_now = 4'd0; do_read(16'h300B);
    iter_now = 4'd9; stale_limit = 4'd0; do_read(16'h300B);

    // R2: upper bound inclusive (bounded) and one above (normal)
    iter_now = 4'd2; do_read(16'h2100); do_read(16'h2101);
    iter_now = 4'd8; stale_limit = 4'd1; do_read(16'h2100); do_read(16'h2101);

    // sweep iterations, thresholds and conflicting addresses
    for (int it = 0; it < 60; it++) begin
      iter_now = 4'((it * 3) & 15);
      stale_limit = 4'(it % 5);
      for (int k = 0; k < 8; k++)
        if (it % (k % 4 + 1) == 0) do_read(alist[k]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule